// File: doc/BRIEF.md
# Rotating Eight-Level Interrupt Priority Resolver

This block picks which pending interrupt level an interrupt controller hands to the processor next. Each cycle it takes the pending request vector, a per-level mask vector, the in-service vector and a nesting-mode select. It returns a one-hot grant, the grant's level number and a valid flag, all registered. A request wins only when it is unmasked, is the highest-priority pending level, and may preempt whatever is already in service.

Priority can rotate. A stored 3-bit pointer names the lowest-priority level, and the level just above it in cyclic order is the highest. Internally the request and in-service vectors are rotated right so that the highest-priority level sits at bit 0. The lowest set bit is then picked, and the result is rotated back left. Two modes are offered. In the fully nested mode, a level already in service blocks itself and every level below it. In the special nested mode, the in-service level may be granted again, which suits a cascaded source that carries several requests behind one level.

Top module: `irq_prio_resolver`

## Requirements
- R1: A synchronous active-high reset clears grant_o, grant_idx_o and grant_vld_o to zero on the next rising edge. It also sets the stored pointer to 7, so level 0 is the highest priority.
- R2: A level whose bit in mask_i is 1 is never granted, whatever its request.
- R3: grant_o is zero or one-hot, with bit n meaning level n. grant_vld_o is 1 exactly when grant_o is non-zero. When valid, grant_idx_o is the binary number of the granted bit.
- R4: With pointer value P, priority runs downward in the cyclic order P+1, P+2, …, P (all modulo 8). The grant goes to the first level in that order that is requested, unmasked and allowed by R5 or R6.
- R5: With nest_sel_i = 0 (fully nested), a request is allowed only if its priority is strictly higher than the highest-priority level set in in_svc_i. With in_svc_i zero, every level is allowed.
- R6: With nest_sel_i = 1 (special nested), a request at the same level as the highest-priority in-service level is also allowed. Lower levels stay blocked.
- R7: When ptr_wr_i is 1 at a rising edge, ptr_i is stored as the new pointer. The new pointer first affects the result registered at the following edge.
- R8: The outputs registered at a rising edge reflect req_i, mask_i, in_svc_i and nest_sel_i as sampled at that edge, together with the pointer held before it. That is one cycle of latency.
- R9: When no level qualifies, grant_o is 0, grant_idx_o is 0 and grant_vld_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 8 | Pending request per level |
| mask_i | input | 8 | Per-level mask, 1 = blocked |
| in_svc_i | input | 8 | Levels currently in service |
| nest_sel_i | input | 1 | 0 = fully nested, 1 = special nested |
| ptr_wr_i | input | 1 | Load strobe for the lowest-priority pointer |
| ptr_i | input | 3 | New lowest-priority level |
| grant_o | output | 8 | One-hot granted level |
| grant_idx_o | output | 3 | Number of the granted level |
| grant_vld_o | output | 1 | A level is granted |

## Verification
The embedded assertions check on every cycle that the grant is one-hot or empty and agrees with the valid flag and the index. They also check that the grant never lands on a level that was masked or not requested, that fully nested mode never re-grants an in-service level, and that an empty unmasked request set yields no grant. Only the bench's reference model can show the rotated priority order, the exact preemption boundary in each nesting mode, and the timing of a pointer write and of a reset that restores the pointer. It checks these against directed patterns and a long random run.

// File: rtl/irq_rslv_pkg.sv
package irq_rslv_pkg;
  // Nesting discipline applied against the in-service vector
  typedef enum logic {
    NEST_FULL    = 1'b0,
    NEST_SPECIAL = 1'b1
  } nest_e;

  localparam int unsigned LVL_N_DEF = 8;
endpackage

// File: rtl/irq_rot.sv
// Cyclic rotation by a run-time amount; DIR_LEFT picks the direction.
module irq_rot #(
  parameter int unsigned N        = 8,
  parameter bit          DIR_LEFT = 1'b0,
  localparam int unsigned IW      = $clog2(N)
) (
  input  logic [N-1:0]  din,
  input  logic [IW-1:0] amt,
  output logic [N-1:0]  dout
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      logic [IW-1:0] src;
      if (DIR_LEFT) begin : g_l
        assign src = IW'(i) - amt;
      end else begin : g_r
        assign src = IW'(i) + amt;
      end
      assign dout[i] = din[src];
    end
  endgenerate
endmodule

// File: rtl/irq_lsb_pick.sv
// Isolates the lowest set bit (bit 0 = highest priority after rotation).
module irq_lsb_pick #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] din,
  output logic [N-1:0] dout,
  output logic         any
);
  localparam logic [N-1:0] ONE = N'(1);
  assign dout = din & (~din + ONE);
  assign any  = |din;
endmodule

// File: rtl/irq_oh2num.sv
// One-hot to binary encoder; zero input encodes to zero.
module irq_oh2num #(
  parameter int unsigned N  = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  oh,
  output logic [IW-1:0] num
);
  always_comb begin
    num = '0;
    for (int i = 0; i < N; i++) begin
      if (oh[i]) num = num | IW'(i);
    end
  end
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import irq_rslv_pkg::*;
#(
  parameter int unsigned LVL_N = LVL_N_DEF,
  localparam int unsigned IW   = $clog2(LVL_N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_N-1:0] req_i,
  input  logic [LVL_N-1:0] mask_i,
  input  logic [LVL_N-1:0] in_svc_i,
  input  logic             nest_sel_i,
  input  logic             ptr_wr_i,
  input  logic [IW-1:0]    ptr_i,
  output logic [LVL_N-1:0] grant_o,
  output logic [IW-1:0]    grant_idx_o,
  output logic             grant_vld_o
);
  localparam logic [LVL_N-1:0] ONE   = LVL_N'(1);
  localparam logic [IW-1:0]    PTR_RST = IW'(LVL_N - 1);

  nest_e nest_mode;
  assign nest_mode = nest_e'(nest_sel_i);

  // Lowest-priority pointer (R1, R7)
  logic [IW-1:0] low_ptr_q;
  always_ff @(posedge clk) begin
    if (rst)           low_ptr_q <= PTR_RST;
    else if (ptr_wr_i) low_ptr_q <= ptr_i;
  end

  // Base shift: highest-priority level moves to bit 0
  logic [IW-1:0] base;
  assign base = low_ptr_q + IW'(1);

  logic [LVL_N-1:0] live_req, rot_req, rot_svc;
  assign live_req = req_i & ~mask_i;

  irq_rot #(.N(LVL_N), .DIR_LEFT(1'b0)) u_rot_req (
    .din(live_req), .amt(base), .dout(rot_req));
  irq_rot #(.N(LVL_N), .DIR_LEFT(1'b0)) u_rot_svc (
    .din(in_svc_i), .amt(base), .dout(rot_svc));

  // Highest in-service level in rotated space
  logic [LVL_N-1:0] svc_top;
  logic             svc_any;
  irq_lsb_pick #(.N(LVL_N)) u_pick_svc (
    .din(rot_svc), .dout(svc_top), .any(svc_any));

  // Prefix of levels allowed to preempt
  logic [LVL_N-1:0] allow;
  always_comb begin
    if (!svc_any)                     allow = '1;
    else if (nest_mode == NEST_SPECIAL) allow = (svc_top - ONE) | svc_top;
    else                              allow = svc_top - ONE;
  end

  logic [LVL_N-1:0] win_rot, win;
  logic             win_any;
  irq_lsb_pick #(.N(LVL_N)) u_pick_req (
    .din(rot_req & allow), .dout(win_rot), .any(win_any));

  irq_rot #(.N(LVL_N), .DIR_LEFT(1'b1)) u_rot_back (
    .din(win_rot), .amt(base), .dout(win));

  logic [IW-1:0] win_idx;
  irq_oh2num #(.N(LVL_N)) u_enc (.oh(win), .num(win_idx));

  // Registered result (R8)
  always_ff @(posedge clk) begin
    if (rst) begin
      grant_o     <= '0;
      grant_idx_o <= '0;
      grant_vld_o <= 1'b0;
    end else begin
      grant_o     <= win;
      grant_idx_o <= win_idx;
      grant_vld_o <= win_any;
    end
  end

  // ---------------- assertions ----------------
  a_r3_grant_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o));

  a_r3_vld_matches: assert property (@(posedge clk) disable iff (rst)
    grant_vld_o == (grant_o != '0));

  a_r3_idx_matches: assert property (@(posedge clk) disable iff (rst)
    grant_vld_o |-> grant_o[grant_idx_o]);

  a_r2_never_masked: assert property (@(posedge clk) disable iff (rst)
    (grant_o & $past(mask_i)) == '0);

  a_r4_only_requested: assert property (@(posedge clk) disable iff (rst)
    (grant_o & ~$past(req_i)) == '0);

  a_r5_no_regrant_full: assert property (@(posedge clk) disable iff (rst)
    ($past(nest_sel_i) == 1'b0) |-> ((grant_o & $past(in_svc_i)) == '0));

  a_r9_empty_no_grant: assert property (@(posedge clk) disable iff (rst)
    (($past(req_i & ~mask_i) == '0) && !$past(rst)) |-> !grant_vld_o);
endmodule

// File: tb/irq_prio_resolver_tb_top.sv
module irq_prio_resolver_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] req = '0, mask = '0, isr = '0;
  logic       sfn = 1'b0, pwr = 1'b0;
  logic [2:0] pval = '0;
  logic [7:0] grant;
  logic [2:0] gidx;
  logic       gvld;

  int n_chk = 0, n_fail = 0;
  logic [7:0] e_grant = '0;
  logic [2:0] e_idx = '0;
  logic       e_vld = 1'b0;
  int         mptr = 7;
  string      e_tag = "R1";

  always #10 clk = ~clk;

  irq_prio_resolver dut_i (
    .clk(clk), .rst(rst), .req_i(req), .mask_i(mask), .in_svc_i(isr),
    .nest_sel_i(sfn), .ptr_wr_i(pwr), .ptr_i(pval),
    .grant_o(grant), .grant_idx_o(gidx), .grant_vld_o(gvld));

  // Behavioural reference: walk levels in priority order
  task automatic ref_model(input logic [7:0] r, m, s, input logic nest,
                           input int p, output logic [7:0] g,
                           output logic [2:0] ix, output logic v);
    int top = 8;
    g = '0; ix = '0; v = 1'b0;
    for (int k = 0; k < 8; k++)
      if (s[(p + 1 + k) % 8] && top == 8) top = k;
    for (int k = 0; k < 8; k++) begin
      int lvl = (p + 1 + k) % 8;
      bit ok = nest ? (k <= top) : (k < top);
      if (!v && r[lvl] && !m[lvl] && ok) begin
        v = 1'b1; g[lvl] = 1'b1; ix = 3'(lvl);
      end
    end
  endtask

  task automatic cyc(input string tag, input logic [7:0] r, m, s,
                     input logic nest, input logic wr, input logic [2:0] pv,
                     input logic rs);
    @(negedge clk);
    n_chk++;
    if (grant !== e_grant || gidx !== e_idx || gvld !== e_vld) begin
      n_fail++;
      $display("FAIL %s: got grant=%b idx=%0d vld=%b, expected grant=%b idx=%0d vld=%b",
               e_tag, grant, gidx, gvld, e_grant, e_idx, e_vld);
    end
    req = r; mask = m; isr = s; sfn = nest; pwr = wr; pval = pv; rst = rs;
    e_tag = tag;
    if (rs) begin
      e_grant = '0; e_idx = '0; e_vld = 1'b0; mptr = 7;
    end else begin
      ref_model(r, m, s, nest, mptr, e_grant, e_idx, e_vld);
      if (wr) mptr = int'(pv);
    end
  endtask

  initial begin
    fork
      begin
        // R1: reset holds outputs at zero
        for (int i = 0; i < 3; i++) cyc("R1", 8'hFF, 8'h00, 8'h00, 0, 0, 3'd0, 1);
        // R4: default order, level 0 highest
        cyc("R4", 8'h81, 8'h00, 8'h00, 0, 0, 3'd0, 0);
        cyc("R4", 8'hF0, 8'h00, 8'h00, 0, 0, 3'd0, 0);
        cyc("R4", 8'h80, 8'h00, 8'h00, 0, 0, 3'd0, 0);
        // R2: masked levels skipped
        cyc("R2", 8'h81, 8'h01, 8'h00, 0, 0, 3'd0, 0);
        cyc("R2", 8'hFF, 8'hFF, 8'h00, 0, 0, 3'd0, 0);
        cyc("R2", 8'h0C, 8'h04, 8'h00, 0, 0, 3'd0, 0);
        // R7: pointer write, effect one edge later
        cyc("R7", 8'h81, 8'h00, 8'h00, 0, 1, 3'd3, 0);
        cyc("R7", 8'h81, 8'h00, 8'h00, 0, 0, 3'd0, 0);
        cyc("R7", 8'h18, 8'h00, 8'h00, 0, 0, 3'd0, 0);
        cyc("R7", 8'h18, 8'h00, 8'h00, 0, 1, 3'd4, 0);
        cyc("R7", 8'h18, 8'h00, 8'h00, 0, 0, 3'd0, 0);
        // R5: fully nested blocking (pointer now 4, level 5 highest)
        cyc("R5", 8'h40, 8'h00, 8'h40, 0, 0, 3'd0, 0);
        cyc("R5", 8'h60, 8'h00, 8'h40, 0, 0, 3'd0, 0);
        cyc("R5", 8'h01, 8'h00, 8'h80, 0, 0, 3'd0, 0);
        // R6: special nested allows same level
        cyc("R6", 8'h40, 8'h00, 8'h40, 1, 0, 3'd0, 0);
        cyc("R6", 8'h80, 8'h00, 8'h40, 1, 0, 3'd0, 0);
        cyc("R6", 8'hC0, 8'h00, 8'h60, 1, 0, 3'd0, 0);
        // R9: nothing qualifies
        cyc("R9", 8'h00, 8'h00, 8'h00, 0, 0, 3'd0, 0);
        cyc("R9", 8'h10, 8'h00, 8'h20, 0, 0, 3'd0, 0);
        // R1: mid-run reset restores pointer 7
        cyc("R1", 8'h81, 8'h00, 8'h00, 0, 0, 3'd0, 1);
        cyc("R1", 8'h81, 8'h00, 8'h00, 0, 0, 3'd0, 0);
        // R3 / R8: random traffic, per-cycle comparison
        for (int i = 0; i < 3000; i++)
          cyc((i % 2) ? "R8" : "R3", 8'($urandom), 8'($urandom & $urandom),
              8'($urandom & $urandom), 1'($urandom), 1'(($urandom % 8) == 0),
              3'($urandom), 1'(($urandom % 500) == 0));
        cyc("R8", 8'h00, 8'h00, 8'h00, 0, 0, 3'd0, 0);
      end
      begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule